// File: doc/BRIEF.md
# PLL power-up and lock sequencer

This block brings a phase-locked loop from cold to locked without software in the loop. A single start pulse launches a timed program. The block first pulses a test/reset bit. It then steps an 8-bit global configuration code through a power-up ramp and arms lock detection with an 8-bit detector code. Last, it samples a synchronised lock input at one defined instant. Every hold time is written in microseconds and turned into clock cycles through the `CYCLES_PER_US` parameter. One down-counter times all the steps.

When lock is missing at the sample instant and attempts remain, the block pulses the reset bit again. It then runs a longer recovery ramp, which drops the configuration back to an intermediate level before it climbs to full power, and tries the lock again. When lock is seen, the block raises `done_o`. When the attempts run out, it raises `fail_o`. Both flags hold until the next start. The configuration codes stay at their last values, so the PLL is left powered.

Top module: `pll_lock_seq`

## Requirements
- R1: A synchronous active-high reset returns the block to idle: all codes are 0x00, and the reset bit, busy, done and fail are all 0.
- R2: A start pulse taken while not busy raises busy and clears done, fail and both codes in the same cycle. Before every ramp, the reset bit is 1 for 1 µs and then 0 for 1 µs.
- R3: The first ramp drives the global code 0x01, 0x05, 0x07 and then 0x0F, held 1, 200, 500 and 500 µs in turn.
- R4: After each ramp, the detector code is left unchanged for 100 µs. It then reads 0x0C for 100 µs and then 0x0D. The lock input, after SYNC_STAGES synchroniser flops, is sampled in the last of SYNC_STAGES+1 cycles of 0x0D.
- R5: After a failed sample with attempts left, a reset pulse follows and then the recovery ramp: 0x01, 0x05, 0x07, 0x05, 0x07 and 0x0F, held 1, 200, 250, 200, 500 and 500 µs. During that reset pulse the global code stays 0x0F and the detector code stays 0x0D.
- R6: At most MAX_ATTEMPTS (default 2) samples are taken. The first sample that sees lock ends the run with done=1. A failed last sample ends it with fail=1. In both cases busy drops, and the codes stay at 0x0F and 0x0D.
- R7: Lock levels outside the sample instant have no effect on the sequence or on the outcome.
- R8: A start pulse while busy is ignored: codes and timing carry on unchanged.
- R9: done and fail hold until the next start. A start from either state begins a fresh run.
- R10: Each hold lasts exactly its microsecond value times CYCLES_PER_US clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| lock_i | input | 1 | Asynchronous lock indication from the PLL |
| glb_cfg_o | output | 8 | Global configuration code |
| lkdet_cfg_o | output | 8 | Lock-detector configuration code |
| test_rst_o | output | 1 | Software reset bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Lock achieved, held until next start |
| fail_o | output | 1 | Attempts exhausted, held until next start |

## Verification
A cycle-accurate scoreboard compares every output on every cycle against segment lists computed in the bench. An off-by-one hold, or a recovery ramp that skips the dip to 0x05, therefore shows up at the exact cycle where it happens. The bench varies the attempt on which the modelled PLL locks, including never. A design that counts attempts wrongly would then report done or fail at the wrong point, or run a third ramp. Lock glitches during the ramp, and a lock level that is high through the 0x0C window but low at the sample, catch a design that samples early or latches lock. Start pulses in mid-ramp catch a design that restarts or stretches a hold when it should ignore the request.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SWR_SET,
      ST_SWR_CLR,
      ST_RAMP,
      ST_LK_SETTLE,
      ST_LK_ARM,
      ST_LK_SAMPLE,
      ST_LOCKED,
      ST_FAILED
   } seq_state_e;

   localparam int unsigned SWR_US       = 1;
   localparam int unsigned LK_SETTLE_US = 100;
   localparam int unsigned LK_ARM_US    = 100;
   localparam int unsigned LONGEST_US   = 500;

   localparam int unsigned FAST_STEPS = 4;
   localparam int unsigned SLOW_STEPS = 6;
   localparam int unsigned STEP_IDX_W = 3;

   localparam logic [7:0] LK_CODE_ARM = 8'h0C;
   localparam logic [7:0] LK_CODE_RUN = 8'h0D;

endpackage

// File: rtl/pll_ramp_rom.sv
module pll_ramp_rom
   import pll_seq_pkg::*;
#(
   parameter int unsigned CYCLES_PER_US = 19,
   parameter int unsigned HOLD_W        = 14
) (
   input  logic                  slow_i,
   input  logic [STEP_IDX_W-1:0] idx_i,
   output logic [7:0]            code_o,
   output logic [HOLD_W-1:0]     len_o
);

   int unsigned us;

   always_comb begin
      code_o = 8'h00;
      us     = 1;
      if (!slow_i) begin
         case (idx_i)
            3'd0:    begin code_o = 8'h01; us = 1;   end
            3'd1:    begin code_o = 8'h05; us = 200; end
            3'd2:    begin code_o = 8'h07; us = 500; end
            3'd3:    begin code_o = 8'h0F; us = 500; end
            default: begin code_o = 8'h0F; us = 1;   end
         endcase
      end else begin
         case (idx_i)
            3'd0:    begin code_o = 8'h01; us = 1;   end
            3'd1:    begin code_o = 8'h05; us = 200; end
            3'd2:    begin code_o = 8'h07; us = 250; end
            3'd3:    begin code_o = 8'h05; us = 200; end
            3'd4:    begin code_o = 8'h07; us = 500; end
            3'd5:    begin code_o = 8'h0F; us = 500; end
            default: begin code_o = 8'h0F; us = 1;   end
         endcase
      end
   end

   assign len_o = HOLD_W'(us * CYCLES_PER_US - 1);

endmodule

// File: rtl/pll_hold_timer.sv
module pll_hold_timer #(
   parameter int unsigned HOLD_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [HOLD_W-1:0] load_val_i,
   output logic              expired_o
);

   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   assert_count_down_R10 : assert property (@(posedge clk) disable iff (rst)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_load_R10 : assert property (@(posedge clk) disable iff (rst)
      load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) ff_q <= '0;
            else     ff_q <= async_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) ff_q <= '0;
            else     ff_q <= {ff_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign sync_o = ff_q[STAGES-1];

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
   import pll_seq_pkg::*;
#(
   parameter int unsigned CYCLES_PER_US = 19,
   parameter int unsigned MAX_ATTEMPTS  = 2,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start_i,
   input  logic       lock_i,
   output logic [7:0] glb_cfg_o,
   output logic [7:0] lkdet_cfg_o,
   output logic       test_rst_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       fail_o
);

   localparam int unsigned HOLD_W = $clog2(LONGEST_US * CYCLES_PER_US + 1);
   localparam int unsigned ATT_W  = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;
   localparam logic [ATT_W-1:0]  LAST_ATT   = ATT_W'(MAX_ATTEMPTS - 1);
   localparam logic [HOLD_W-1:0] SWR_LD     = HOLD_W'(SWR_US * CYCLES_PER_US - 1);
   localparam logic [HOLD_W-1:0] SETTLE_LD  = HOLD_W'(LK_SETTLE_US * CYCLES_PER_US - 1);
   localparam logic [HOLD_W-1:0] ARM_LD     = HOLD_W'(LK_ARM_US * CYCLES_PER_US - 1);
   localparam logic [HOLD_W-1:0] SAMPLE_LD  = HOLD_W'(SYNC_STAGES);
   localparam logic [STEP_IDX_W-1:0] FAST_LAST = STEP_IDX_W'(FAST_STEPS - 1);
   localparam logic [STEP_IDX_W-1:0] SLOW_LAST = STEP_IDX_W'(SLOW_STEPS - 1);

   generate
      if (CYCLES_PER_US < 1) begin : g_bad_cpu
         $error("CYCLES_PER_US must be at least 1");
      end
      if (MAX_ATTEMPTS < 1) begin : g_bad_att
         $error("MAX_ATTEMPTS must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   seq_state_e            st_q, st_d;
   logic [STEP_IDX_W-1:0] idx_q, idx_d, rom_idx;
   logic                  slow_q, slow_d;
   logic [ATT_W-1:0]      att_q, att_d;
   logic                  adv;
   logic [HOLD_W-1:0]     ld_val;
   logic                  expired;
   logic                  lock_s;
   logic [7:0]            rom_code;
   logic [HOLD_W-1:0]     rom_len;
   logic [STEP_IDX_W-1:0] ramp_last;

   pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .async_i(lock_i),
      .sync_o (lock_s)
   );

   pll_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .load_i    (adv),
      .load_val_i(ld_val),
      .expired_o (expired)
   );

   assign rom_idx   = (st_q == ST_RAMP) ? idx_q + 1'b1 : '0;
   assign ramp_last = slow_q ? SLOW_LAST : FAST_LAST;

   pll_ramp_rom #(.CYCLES_PER_US(CYCLES_PER_US), .HOLD_W(HOLD_W)) u_rom (
      .slow_i(slow_q),
      .idx_i (rom_idx),
      .code_o(rom_code),
      .len_o (rom_len)
   );

   always_comb begin
      st_d   = st_q;
      idx_d  = idx_q;
      slow_d = slow_q;
      att_d  = att_q;
      adv    = 1'b0;
      ld_val = '0;
      case (st_q)
         ST_IDLE, ST_LOCKED, ST_FAILED: begin
            if (start_i) begin
               adv    = 1'b1;
               st_d   = ST_SWR_SET;
               slow_d = 1'b0;
               att_d  = '0;
               ld_val = SWR_LD;
            end
         end
         ST_SWR_SET: begin
            if (expired) begin
               adv    = 1'b1;
               st_d   = ST_SWR_CLR;
               ld_val = SWR_LD;
            end
         end
         ST_SWR_CLR: begin
            if (expired) begin
               adv    = 1'b1;
               st_d   = ST_RAMP;
               idx_d  = '0;
               ld_val = rom_len;
            end
         end
         ST_RAMP: begin
            if (expired) begin
               adv = 1'b1;
               if (idx_q == ramp_last) begin
                  st_d   = ST_LK_SETTLE;
                  ld_val = SETTLE_LD;
               end else begin
                  idx_d  = rom_idx;
                  ld_val = rom_len;
               end
            end
         end
         ST_LK_SETTLE: begin
            if (expired) begin
               adv    = 1'b1;
               st_d   = ST_LK_ARM;
               ld_val = ARM_LD;
            end
         end
         ST_LK_ARM: begin
            if (expired) begin
               adv    = 1'b1;
               st_d   = ST_LK_SAMPLE;
               ld_val = SAMPLE_LD;
            end
         end
         ST_LK_SAMPLE: begin
            if (expired) begin
               adv = 1'b1;
               if (lock_s) begin
                  st_d = ST_LOCKED;
               end else if (att_q == LAST_ATT) begin
                  st_d = ST_FAILED;
               end else begin
                  st_d   = ST_SWR_SET;
                  slow_d = 1'b1;
                  att_d  = att_q + 1'b1;
                  ld_val = SWR_LD;
               end
            end
         end
         default: begin
            adv  = 1'b1;
            st_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q        <= ST_IDLE;
         idx_q       <= '0;
         slow_q      <= 1'b0;
         att_q       <= '0;
         glb_cfg_o   <= 8'h00;
         lkdet_cfg_o <= 8'h00;
         test_rst_o  <= 1'b0;
         done_o      <= 1'b0;
         fail_o      <= 1'b0;
      end else if (adv) begin
         st_q   <= st_d;
         idx_q  <= idx_d;
         slow_q <= slow_d;
         att_q  <= att_d;
         case (st_d)
            ST_SWR_SET: begin
               test_rst_o <= 1'b1;
               if (st_q == ST_IDLE || st_q == ST_LOCKED || st_q == ST_FAILED) begin
                  glb_cfg_o   <= 8'h00;
                  lkdet_cfg_o <= 8'h00;
                  done_o      <= 1'b0;
                  fail_o      <= 1'b0;
               end
            end
            ST_SWR_CLR:   test_rst_o  <= 1'b0;
            ST_RAMP:      glb_cfg_o   <= rom_code;
            ST_LK_ARM:    lkdet_cfg_o <= LK_CODE_ARM;
            ST_LK_SAMPLE: lkdet_cfg_o <= LK_CODE_RUN;
            ST_LOCKED:    done_o      <= 1'b1;
            ST_FAILED:    fail_o      <= 1'b1;
            default: ;
         endcase
      end
   end

   assign busy_o = !(st_q == ST_IDLE || st_q == ST_LOCKED || st_q == ST_FAILED);

   assert_test_only_busy_R2 : assert property (@(posedge clk) disable iff (rst)
      test_rst_o |-> busy_o);

   assert_outcome_exclusive_R6 : assert property (@(posedge clk) disable iff (rst)
      !(done_o && fail_o));

   assert_end_not_busy_R6 : assert property (@(posedge clk) disable iff (rst)
      (done_o || fail_o) |-> !busy_o);

   assert_lkdet_legal_R4 : assert property (@(posedge clk) disable iff (rst)
      (lkdet_cfg_o == 8'h00 || lkdet_cfg_o == LK_CODE_ARM || lkdet_cfg_o == LK_CODE_RUN));

   assert_done_from_sample_R7 : assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> ($past(lock_s) && $past(st_q) == ST_LK_SAMPLE));

   assert_done_hold_R9 : assert property (@(posedge clk) disable iff (rst)
      (done_o && !start_i) |=> done_o);

   assert_fail_hold_R9 : assert property (@(posedge clk) disable iff (rst)
      (fail_o && !start_i) |=> fail_o);

   assert_busy_start_ignored_R8 : assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i && st_q != ST_RAMP && st_q != ST_SWR_CLR) |=> $stable(glb_cfg_o));

endmodule

// File: tb/pll_lock_seq_test.sv
module pll_lock_seq_test;

   localparam int CPU  = 2;
   localparam int MAXA = 2;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_i = 1'b0;
   logic       lock_i = 1'b0;
   logic [7:0] glb_cfg_o, lkdet_cfg_o;
   logic       test_rst_o, busy_o, done_o, fail_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int fast_code [4] = '{8'h01, 8'h05, 8'h07, 8'h0F};
   int fast_us   [4] = '{1, 200, 500, 500};
   int slow_code [6] = '{8'h01, 8'h05, 8'h07, 8'h05, 8'h07, 8'h0F};
   int slow_us   [6] = '{1, 200, 250, 200, 500, 500};

   always #10 clk = ~clk;

   pll_lock_seq #(.CYCLES_PER_US(CPU), .MAX_ATTEMPTS(MAXA), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst(rst), .start_i(start_i), .lock_i(lock_i),
      .glb_cfg_o(glb_cfg_o), .lkdet_cfg_o(lkdet_cfg_o), .test_rst_o(test_rst_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
   );

   task automatic seg(input bit t, input logic [7:0] g, input logic [7:0] l,
                      input bit b, input bit d, input bit f, input int n,
                      input bit lk, input int poke, input string req);
      bit bad = 0;
      int at = 0;
      logic [7:0] ag = 0, al = 0;
      logic at_t = 0, ab = 0, ad = 0, af = 0;
      lock_i = lk;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (!bad && (test_rst_o !== t || glb_cfg_o !== g || lkdet_cfg_o !== l ||
                      busy_o !== b || done_o !== d || fail_o !== f)) begin
            bad = 1; at = i;
            at_t = test_rst_o; ag = glb_cfg_o; al = lkdet_cfg_o;
            ab = busy_o; ad = done_o; af = fail_o;
         end
         if (i == poke) start_i = 1'b1;
      end
      checks++;
      if (bad) begin
         errors++;
         $display("FAIL %s cycle %0d of %0d: got t=%0b g=%h l=%h b=%0b d=%0b f=%0b, expected t=%0b g=%h l=%h b=%0b d=%0b f=%0b",
                  req, at, n, at_t, ag, al, ab, ad, af, t, g, l, b, d, f);
      end
   endtask

   task automatic kick();
      @(negedge clk);
      start_i = 1'b1;
      @(posedge clk);
      start_i <= 1'b0;
   endtask

   // lock_at: attempt number (1-based) on which the PLL model locks; larger than MAXA means never
   task automatic run(input int lock_at, input bit glitch, input bit poke, input string tag);
      logic [7:0] pg, pl;
      bit ok = 0;
      int pk;
      kick();
      for (int a = 0; a < MAXA; a++) begin
         pg = (a == 0) ? 8'h00 : 8'h0F;
         pl = (a == 0) ? 8'h00 : 8'h0D;
         seg(1, pg, pl, 1, 0, 0, CPU, 0, -1, {tag, " R2 reset pulse high"});
         seg(0, pg, pl, 1, 0, 0, CPU, 0, -1, {tag, " R2 reset pulse low"});
         if (a == 0) begin
            for (int s = 0; s < 4; s++) begin
               pk = (poke && s == 2) ? 37 : -1;
               seg(0, 8'(fast_code[s]), pl, 1, 0, 0, fast_us[s] * CPU, glitch && s == 2, pk,
                   {tag, " R3 R10 R8 first ramp step"});
            end
         end else begin
            for (int s = 0; s < 6; s++) begin
               pk = (poke && s == 3) ? 11 : -1;
               seg(0, 8'(slow_code[s]), pl, 1, 0, 0, slow_us[s] * CPU, glitch && s == 4, pk,
                   {tag, " R5 R10 R8 recovery ramp step"});
            end
         end
         seg(0, 8'h0F, pl, 1, 0, 0, 100 * CPU, 0, -1, {tag, " R4 settle wait"});
         seg(0, 8'h0F, 8'h0C, 1, 0, 0, 100 * CPU, glitch, -1, {tag, " R4 R7 arm window"});
         ok = (a + 1 >= lock_at);
         seg(0, 8'h0F, 8'h0D, 1, 0, 0, SYNC + 1, ok, -1, {tag, " R4 sample window"});
         if (ok) break;
      end
      seg(0, 8'h0F, 8'h0D, 0, ok, !ok, 6, 0, -1, {tag, " R6 R7 R9 outcome held"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      seg(0, 8'h00, 8'h00, 0, 0, 0, 4, 0, -1, "R1 idle after reset");
      // directed corner cases
      run(1, 0, 0, "lock first");
      run(2, 0, 0, "lock second");
      run(3, 0, 0, "never locks");
      run(3, 1, 1, "glitch no lock");
      run(2, 1, 1, "glitch lock second");
      // R1: reset in the middle of a ramp
      kick();
      repeat (500) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      seg(0, 8'h00, 8'h00, 0, 0, 0, 5, 0, -1, "R1 reset mid-run");
      // constrained random runs
      for (int k = 0; k < 5; k++) begin
         int la;
         bit gl, pk;
         la = int'($urandom_range(1, 3));
         gl = 1'($urandom_range(0, 1));
         pk = 1'($urandom_range(0, 1));
         run(la, gl, pk, "random");
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule